// File: doc/BRIEF.md
# Handshaking Parallel Port Adapter

This block sits between a processor bus and two 8-bit peripheral ports, labelled side A and side B. The processor reaches six registers through a two-bit register select. Each side has a direction register, an output register and a control register. The data address of each side reaches either the direction register or the port, and a bit in that side's control register chooses which. Each port line is an input or an output, set one bit at a time. A read of the port returns a mix of pin values and output register values.

Each side has two control lines. The first is always an edge-sensitive input, and its active edge is programmable. The second is either a second edge-sensitive input or an output. As an output it works in one of three modes: a read/write handshake, a one-cycle strobe, or a level set directly by software. Each side drives its own active-low interrupt request from its latched edge flags, gated by their enables. Reading the port clears those flags.

The bus timing is modelled as one synchronous enable strobe. An access takes effect at the clock edge that ends the cycle in which the strobe is high.

Top module: `hsk_port_adapter`

## Requirements
- R1: After reset, every register reads 0. All port lines and both second control lines are inputs (all output enables are 0), and both interrupt outputs are high.
- R2: Output enable bit n of a port equals bit n of that side's direction register, and the port output equals that side's output register.
- R3: An access happens only in a cycle where en_i=1 and cs_i=3'b011. rs_i selects the register: 00 is side A data, 01 is side A control, 10 is side B data, 11 is side B control. A data address reaches the direction register when control bit 2 is 0, and the port/output register when it is 1.
- R4: A port read returns the output register bit where the direction bit is 1, and the pin value where it is 0.
- R5: Control bit 7 is set by an active edge on the first control input. Control bit 1 chooses the active edge (1 = rising, 0 = falling). The side's interrupt output goes low while the flag is set and control bit 0 is 1.
- R6: When control bit 5 is 0, the second control line is an input. Its active edge, chosen by bit 4 (1 = rising), sets control bit 6. Bit 3 enables that flag onto the interrupt output.
- R7: A port read (data address with control bit 2 = 1) clears both flags of that side. A direction-register read does not clear them, and neither does a control read.
- R8: Control bits 7 and 6 are read-only. Writing to them leaves them unchanged.
- R9: In handshake mode (control bits 5..3 = 100), the side A second line goes low in the cycle after a side A port read. It returns high in the cycle after the next active edge on the side A first control input.
- R10: In handshake mode, the side B second line goes low after a side B port write, and returns high after the next active edge on the side B first input. A side B port read does not lower it.
- R11: In strobe mode (bits 5..3 = 101), the second line is low for exactly one cycle, the one after the triggering access.
- R12: In manual mode (bits 5..4 = 11), the second line drives the value of control bit 3.
- R13: A write with a wrong chip-select pattern changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 3 | Chip selects; 3'b011 selects the block |
| rs_i | input | 2 | Register select |
| rd_i | input | 1 | 1 = read, 0 = write |
| en_i | input | 1 | Access strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0 outside a read access |
| pa_i | input | 8 | Side A pin values |
| pa_o | output | 8 | Side A output values |
| pa_oe_o | output | 8 | Side A output enables |
| pb_i | input | 8 | Side B pin values |
| pb_o | output | 8 | Side B output values |
| pb_oe_o | output | 8 | Side B output enables |
| ca1_i | input | 1 | Side A first control input |
| ca2_i | input | 1 | Side A second control line, input value |
| ca2_o | output | 1 | Side A second control line, output value |
| ca2_oe_o | output | 1 | Side A second control line, output enable |
| cb1_i | input | 1 | Side B first control input |
| cb2_i | input | 1 | Side B second control line, input value |
| cb2_o | output | 1 | Side B second control line, output value |
| cb2_oe_o | output | 1 | Side B second control line, output enable |
| irq_a_no | output | 1 | Side A interrupt request, active low |
| irq_b_no | output | 1 | Side B interrupt request, active low |

## Verification
The assertions take for granted that control inputs are already synchronous to the clock. They also assume each control input is low during reset, so that the first sampled level is not read as an edge. Finally, they assume a bus access never writes a control register and touches a data register in the same cycle. The stimulus drives every input at the falling clock edge, holds the control inputs low through reset, and makes one access per strobe. It changes a control input only between accesses.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned C1_IE  = 0;
  localparam int unsigned C1_POL = 1;
  localparam int unsigned DSEL   = 2;
  localparam int unsigned C2_IE  = 3;
  localparam int unsigned C2_POL = 4;
  localparam int unsigned C2_OUT = 5;
  localparam int unsigned CW_W   = C2_OUT + 1;

  typedef enum logic [1:0] {
    C2_IN    = 2'd0,
    C2_HSK   = 2'd1,
    C2_PULSE = 2'd2,
    C2_MAN   = 2'd3
  } c2_mode_e;
endpackage

// File: rtl/hpa_port.sv
module hpa_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_ddr_i,
  input  logic          wr_out_i,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] ddr_o,
  output logic [DW-1:0] out_o,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] ddr_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ddr_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_ddr_i) ddr_q <= wdata_i;
      if (wr_out_i) out_q <= wdata_i;
    end
  end

  assign ddr_o = ddr_q;
  assign out_o = out_q;
  // outputs read back their register, inputs read the pin
  assign rd_o  = (ddr_q & out_q) | (~ddr_q & pin_i);

  // R2
  ddr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_ddr_i) |-> $stable(ddr_q));
endmodule

// File: rtl/hpa_ctrl.sv
module hpa_ctrl
  import hpa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW_W-1:0]  wdata_i,
  input  logic             wr_ctl_i,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic             c1_i,
  input  logic             c2_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             c2_o,
  output logic             c2_oe_o,
  output logic             irq_o
);
  logic [CW_W-1:0] ctl_q;
  logic f1_q, f2_q, c1_q, c2_q, hs_q;
  logic edge1, edge2;
  c2_mode_e mode;

  always_comb begin
    if (!ctl_q[C2_OUT])     mode = C2_IN;
    else if (ctl_q[C2_POL]) mode = C2_MAN;
    else if (ctl_q[C2_IE])  mode = C2_PULSE;
    else                    mode = C2_HSK;
  end

  assign edge1 = (c1_i ^ c1_q) & (c1_i == ctl_q[C1_POL]);
  assign edge2 = (mode == C2_IN) & (c2_i ^ c2_q) & (c2_i == ctl_q[C2_POL]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
      c1_q  <= 1'b0;
      c2_q  <= 1'b0;
      hs_q  <= 1'b1;
    end else begin
      c1_q <= c1_i;
      c2_q <= c2_i;
      if (wr_ctl_i) ctl_q <= wdata_i;
      // a new edge wins over a clear in the same cycle
      if (edge1)      f1_q <= 1'b1;
      else if (clr_i) f1_q <= 1'b0;
      if (edge2)      f2_q <= 1'b1;
      else if (clr_i) f2_q <= 1'b0;
      if (wr_ctl_i)                                        hs_q <= 1'b1;
      else if ((mode == C2_HSK || mode == C2_PULSE) && acc_i) hs_q <= 1'b0;
      else if (mode == C2_PULSE)                           hs_q <= 1'b1;
      else if (mode == C2_HSK && edge1)                    hs_q <= 1'b1;
    end
  end

  assign ctl_o   = {f1_q, f2_q, ctl_q};
  assign c2_oe_o = ctl_q[C2_OUT];
  assign c2_o    = (mode == C2_MAN) ? ctl_q[C2_IE] : hs_q;
  assign irq_o   = (f1_q & ctl_q[C1_IE]) | (f2_q & ctl_q[C2_IE] & ~ctl_q[C2_OUT]);

  // R5
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(f1_q) |-> ($past(c1_i) == $past(ctl_q[C1_POL])));
  // R7
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(f1_q) |-> $past(clr_i));
  // R9
  hs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_q) |-> $past(acc_i));
  // R11
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == C2_PULSE && !hs_q && !acc_i) |=> hs_q);
endmodule

// File: rtl/hsk_port_adapter.sv
module hsk_port_adapter
  import hpa_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cs_i,
  input  logic [1:0]    rs_i,
  input  logic          rd_i,
  input  logic          en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic          ca1_i,
  input  logic          ca2_i,
  output logic          ca2_o,
  output logic          ca2_oe_o,
  input  logic          cb1_i,
  input  logic          cb2_i,
  output logic          cb2_o,
  output logic          cb2_oe_o,
  output logic          irq_a_no,
  output logic          irq_b_no
);
  localparam int unsigned NSIDE = 2;

  logic sel;
  logic [NSIDE-1:0][DW-1:0]    pin, ddr, outr, prd;
  logic [NSIDE-1:0][CTL_W-1:0] ctl;
  logic [NSIDE-1:0] c1, c2, c2o, c2oe, irq;
  logic [NSIDE-1:0] wr_ddr, wr_out, wr_ctl, rd_dat, acc;

  assign sel = en_i & cs_i[0] & cs_i[1] & ~cs_i[2];

  assign pin = {pb_i, pa_i};
  assign c1  = {cb1_i, ca1_i};
  assign c2  = {cb2_i, ca2_i};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic hit;
    assign hit       = sel & (rs_i[1] == 1'(s));
    assign wr_ddr[s] = hit & ~rs_i[0] & ~rd_i & ~ctl[s][DSEL];
    assign wr_out[s] = hit & ~rs_i[0] & ~rd_i &  ctl[s][DSEL];
    assign wr_ctl[s] = hit &  rs_i[0] & ~rd_i;
    assign rd_dat[s] = hit & ~rs_i[0] &  rd_i &  ctl[s][DSEL];
    // side A handshakes on reads, side B on writes
    if (s == 0) begin : g_rd_hs
      assign acc[s] = rd_dat[s];
    end else begin : g_wr_hs
      assign acc[s] = wr_out[s];
    end

    hpa_port #(.DW(DW)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wdata_i  (wdata_i),
      .wr_ddr_i (wr_ddr[s]),
      .wr_out_i (wr_out[s]),
      .pin_i    (pin[s]),
      .ddr_o    (ddr[s]),
      .out_o    (outr[s]),
      .rd_o     (prd[s])
    );

    hpa_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wdata_i  (wdata_i[CW_W-1:0]),
      .wr_ctl_i (wr_ctl[s]),
      .clr_i    (rd_dat[s]),
      .acc_i    (acc[s]),
      .c1_i     (c1[s]),
      .c2_i     (c2[s]),
      .ctl_o    (ctl[s]),
      .c2_o     (c2o[s]),
      .c2_oe_o  (c2oe[s]),
      .irq_o    (irq[s])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (sel && rd_i) begin
      if (rs_i[0])                 rdata_o = DW'(ctl[rs_i[1]]);
      else if (ctl[rs_i[1]][DSEL]) rdata_o = prd[rs_i[1]];
      else                         rdata_o = ddr[rs_i[1]];
    end
  end

  assign pa_o     = outr[0];
  assign pa_oe_o  = ddr[0];
  assign pb_o     = outr[1];
  assign pb_oe_o  = ddr[1];
  assign ca2_o    = c2o[0];
  assign ca2_oe_o = c2oe[0];
  assign cb2_o    = c2o[1];
  assign cb2_oe_o = c2oe[1];
  assign irq_a_no = ~irq[0];
  assign irq_b_no = ~irq[1];

  // R13
  desel_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel) |-> $stable(ctl[0][CW_W-1:0]) && $stable(ctl[1][CW_W-1:0]));
endmodule

// File: tb/hsk_port_adapter_tb_top.sv
module hsk_port_adapter_tb_top;
  localparam time TCK = 8ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [2:0] cs = '0;
  logic [1:0] rs = '0;
  logic rd = 1'b0, en = 1'b0;
  logic [7:0] wdata = '0, rdata, pa_i = '0, pa_o, pa_oe, pb_i = '0, pb_o, pb_oe;
  logic ca1 = 0, ca2 = 0, cb1 = 0, cb2 = 0;
  logic ca2_o, ca2_oe, cb2_o, cb2_oe, irq_a_n, irq_b_n;
  int checks = 0, errors = 0;
  logic [7:0] r;

  always #(TCK/2) clk = ~clk;

  hsk_port_adapter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .rs_i(rs), .rd_i(rd), .en_i(en),
    .wdata_i(wdata), .rdata_o(rdata), .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe), .ca1_i(ca1), .ca2_i(ca2),
    .ca2_o(ca2_o), .ca2_oe_o(ca2_oe), .cb1_i(cb1), .cb2_i(cb2), .cb2_o(cb2_o),
    .cb2_oe_o(cb2_oe), .irq_a_no(irq_a_n), .irq_b_no(irq_b_n)
  );

  // {ddr, out, pin, expected}
  localparam logic [31:0] VEC [6] = '{
    32'hFF_A5_00_A5, 32'h00_A5_3C_3C, 32'hF0_12_34_14,
    32'h0F_12_34_32, 32'hAA_FF_00_AA, 32'h55_00_FF_AA
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic rdn, input logic [1:0] a, input logic [7:0] wd,
                     output logic [7:0] rv, input logic [2:0] c = 3'b011);
    @(negedge clk);
    cs = c; rd = rdn; rs = a; wdata = wd; en = 1'b1;
    #2 rv = rdata;
    @(negedge clk);
    en = 1'b0; cs = '0; rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] wd);
    logic [7:0] d;
    bus(1'b0, a, wd, d);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(TCK * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus(1'b1, 2'(a), 8'h00, r);
      chk("R1 reg", r, 8'h00);
    end
    chk("R1 oe", {pa_oe[3:0], pb_oe[3:0]}, 8'h00);
    chk("R1 misc", {4'b0, ca2_oe, cb2_oe, irq_a_n, irq_b_n}, 8'h03);

    // R13 deselected writes ignored
    bus(1'b0, 2'b00, 8'hFF, r, 3'b111);
    bus(1'b0, 2'b01, 8'h3F, r, 3'b010);
    chk("R13 oe", pa_oe, 8'h00);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R13 ctl", r, 8'h00);

    // R2 R3 R4 vector walk on side A
    foreach (VEC[i]) begin
      wr(2'b01, 8'h00);
      wr(2'b00, VEC[i][31:24]);
      wr(2'b01, 8'h04);
      wr(2'b00, VEC[i][23:16]);
      pa_i = VEC[i][15:8];
      bus(1'b1, 2'b00, 8'h00, r);
      chk("R4 read", r, VEC[i][7:0]);
      chk("R2 oe", pa_oe, VEC[i][31:24]);
      chk("R2 out", pa_o, VEC[i][23:16]);
    end
    // R3 direction register reached with bit2 clear, side B independent
    wr(2'b01, 8'h00);
    bus(1'b1, 2'b00, 8'h00, r);
    chk("R3 ddr", r, 8'h55);
    wr(2'b10, 8'hC3);
    chk("R3 side B ddr", pb_oe, 8'hC3);
    chk("R3 side A kept", pa_oe, 8'h55);

    // R8 flags read-only
    wr(2'b01, 8'hC4);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R8 ctl", r, 8'h04);

    // R5 rising edge with enable
    wr(2'b01, 8'h07);
    ca1 = 1'b1; cyc(1);
    chk("R5 irq", {7'b0, irq_a_n}, 8'h00);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R5 flag", r, 8'h87);
    bus(1'b1, 2'b00, 8'h00, r);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R7 cleared", r, 8'h07);
    chk("R7 irq", {7'b0, irq_a_n}, 8'h01);
    ca1 = 1'b0; cyc(1);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R5 wrong edge", r, 8'h07);
    // R5 falling polarity
    wr(2'b01, 8'h05);
    ca1 = 1'b1; cyc(1);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R5 fall pol rise", r, 8'h05);
    ca1 = 1'b0; cyc(1);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R5 fall pol fall", r, 8'h85);
    // R7 direction read does not clear
    wr(2'b01, 8'h01);
    bus(1'b1, 2'b00, 8'h00, r);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R7 ddr read keeps", r, 8'h81);
    wr(2'b01, 8'h04);
    chk("R5 disabled irq", {7'b0, irq_a_n}, 8'h01);
    bus(1'b1, 2'b00, 8'h00, r);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R7 port read clears", r, 8'h04);

    // R6 second line as input
    wr(2'b01, 8'h1C);
    ca2 = 1'b1; cyc(1);
    bus(1'b1, 2'b01, 8'h00, r);
    chk("R6 flag", r, 8'h5C);
    chk("R6 irq", {7'b0, irq_a_n}, 8'h00);
    bus(1'b1, 2'b00, 8'h00, r);
    chk("R6 cleared irq", {7'b0, irq_a_n}, 8'h01);

    // R9 side A read handshake
    wr(2'b01, 8'h26);
    chk("R9 idle", {6'b0, ca2_oe, ca2_o}, 8'h03);
    bus(1'b1, 2'b00, 8'h00, r);
    chk("R9 low", {7'b0, ca2_o}, 8'h00);
    cyc(3);
    chk("R9 held", {7'b0, ca2_o}, 8'h00);
    ca1 = 1'b1; cyc(1);
    chk("R9 release", {7'b0, ca2_o}, 8'h01);
    ca1 = 1'b0;

    // R11 strobe mode
    wr(2'b01, 8'h2C);
    bus(1'b1, 2'b00, 8'h00, r);
    chk("R11 low", {7'b0, ca2_o}, 8'h00);
    cyc(1);
    chk("R11 high", {7'b0, ca2_o}, 8'h01);

    // R12 manual level
    wr(2'b01, 8'h3C);
    chk("R12 high", {7'b0, ca2_o}, 8'h01);
    wr(2'b01, 8'h34);
    chk("R12 low", {7'b0, ca2_o}, 8'h00);

    // R10 side B write handshake
    wr(2'b11, 8'h26);
    chk("R10 idle", {6'b0, cb2_oe, cb2_o}, 8'h03);
    bus(1'b1, 2'b10, 8'h00, r);
    chk("R10 read no effect", {7'b0, cb2_o}, 8'h01);
    wr(2'b10, 8'h5A);
    chk("R10 low", {7'b0, cb2_o}, 8'h00);
    chk("R10 out", pb_o, 8'h5A);
    cyc(2);
    cb1 = 1'b1; cyc(1);
    chk("R10 release", {7'b0, cb2_o}, 8'h01);
    // R5 side B interrupt
    wr(2'b11, 8'h07);
    cb1 = 1'b0; cyc(1);
    cb1 = 1'b1; cyc(1);
    chk("R5 side B irq", {6'b0, irq_a_n, irq_b_n}, 8'h02);
    // R11 side B strobe
    wr(2'b11, 8'h2C);
    wr(2'b10, 8'h11);
    chk("R11 B low", {7'b0, cb2_o}, 8'h00);
    cyc(1);
    chk("R11 B high", {7'b0, cb2_o}, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule